// File: doc/BRIEF.md
# Serial FPGA Bitstream Loader

This block configures a slave FPGA over a one-bit serial link. On a start request it runs the configuration reset handshake. It pulls the program-request pin low until the FPGA signals that it is clearing its memory by pulling its init pin low. It then releases the program-request pin and waits for the init pin to go high again. After that it reads the bitstream one byte at a time from a byte-wide flash read port and shifts each byte out, most significant bit first. The serial clock idles low, the FPGA samples on the rising edge, and the data changes on the falling edge.

The stream is split into chunks of at most `CHUNK` bytes. The last chunk is cut down to the bytes that are left. After the last byte the block waits a settle time and then reads the two status pins. A low init pin means the FPGA found a CRC error. A high init pin with a low done pin means the configuration did not finish. Both pins high means success. Each handshake wait has a timeout so that a missing FPGA gives an error code instead of a hang.

When the board has no program-request control (`HAS_PROG = 0`), a start only waits a fixed self-configuration time and then reports success. The state machine has these states:
- `S_IDLE`: waits for a start.
- `S_PROG_LOW`: pin driven low; goes to `S_PROG_REL` when init reads low, or to `S_IDLE` with a timeout.
- `S_PROG_REL`: pin released; goes to `S_CHUNK` when init reads high, or to `S_IDLE` with a timeout.
- `S_CHUNK`: sizes the next chunk, or moves to `S_SETTLE` when no bytes remain.
- `S_FETCH`: requests a byte and goes to `S_SHIFT` when the byte is valid.
- `S_SHIFT`: sends the byte, then goes back to `S_FETCH`, or to `S_CHUNK` when the chunk is exhausted.
- `S_SETTLE`: waits the settle time, then judges the pins and returns to `S_IDLE`.
- `S_SELFCFG`: waits the self-configuration time, then returns to `S_IDLE`.

Top module: `bitload_ctrl`

## Requirements
- R1: After reset, `prog_n_o` is 1 and `sclk_o`, `rd_req_o` and `busy_o` are 0. `result_o` is 0 (none).
- R2: A start drives `prog_n_o` low. It stays low until `init_n_i` reads low, and then returns high. `prog_n_o` is never low while `busy_o` is low.
- R3: No flash request and no serial clock pulse happen while `prog_n_o` is low or before `init_n_i` has returned high.
- R4: Exactly `byte_count_i` bytes are requested. Their addresses are consecutive and start at `start_addr_i`. The address is held while a request is pending.
- R5: Each byte is sent most significant bit first, with 8 rising `sclk_o` edges per byte. `sdo_o` changes only while `sclk_o` is low. Each half period of `sclk_o` is `SCK_HALF` clocks.
- R6: Bytes are sent in chunks of at most `CHUNK` bytes. The final chunk holds only the bytes that remain, so any count is delivered exactly, including multiples of `CHUNK`.
- R7: The status pins are judged no earlier than `SETTLE_CYC` clocks after the last serial bit.
- R8: If `init_n_i` is low after the settle time, `result_o` becomes 2 (CRC error).
- R9: If `init_n_i` is high and `done_i` is low, `result_o` becomes 3 (not done). If both are high, `result_o` becomes 1 (success).
- R10: If `init_n_i` does not go low, or does not return high, within `HS_TIMEOUT` clocks, the load ends with `result_o` = 4 (timeout) and `prog_n_o` high.
- R11: With `HAS_PROG = 0`, a start keeps `prog_n_o` high and sends nothing. `busy_o` stays high for at least `SELFCFG_CYC` clocks, and then `result_o` becomes 1.
- R12: A start while `busy_o` is high is ignored. A new accepted start clears `result_o` to 0.
- R13: A byte count of 0 skips streaming and goes straight to the settle wait and the pin check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| start_addr_i | input | ADDR_W | Flash address of the first bitstream byte |
| byte_count_i | input | CNT_W | Number of bytes to send |
| rd_req_o | output | 1 | Flash byte request, held until valid |
| rd_addr_o | output | ADDR_W | Flash byte address |
| rd_data_i | input | 8 | Flash byte data |
| rd_valid_i | input | 1 | Flash data valid |
| init_n_i | input | 1 | FPGA init/error pin, active low |
| done_i | input | 1 | FPGA configuration done pin |
| prog_n_o | output | 1 | Program request to the FPGA, active low |
| sclk_o | output | 1 | Serial configuration clock |
| sdo_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| result_o | output | 3 | 0 none, 1 ok, 2 CRC error, 3 not done, 4 timeout |

## Verification
A wrong state shows at the ports within a few clocks. A missed handshake step puts a flash request or a serial clock pulse on the pins while the init pin is still low. A bad chunk counter shows up at the end of the load as missing or extra bytes, or as bytes whose addresses are not consecutive. A wrong settle or judgement path shows up when the result code arrives, either as a busy window that is too short or as the wrong code. The bench compares every received serial byte with the pattern computed from its address, so a single wrong bit is caught at that byte.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROG_LOW,
        S_PROG_REL,
        S_CHUNK,
        S_FETCH,
        S_SHIFT,
        S_SETTLE,
        S_SELFCFG
    } bl_state_e;

    typedef enum logic [2:0] {
        RES_NONE    = 3'd0,
        RES_OK      = 3'd1,
        RES_CRC     = 3'd2,
        RES_NOTDONE = 3'd3,
        RES_TIMEOUT = 3'd4
    } bl_result_e;

endpackage

// File: rtl/bitload_timer.sv
// Countdown timer: load sets the count, expired is high once it reaches zero.
module bitload_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bitload_serial.sv
// Byte serializer: MSB first, clock idles low, data moves on the falling edge.
module bitload_serial #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       busy,
    output logic       sclk,
    output logic       sdo
);
    localparam int DW = $clog2(HALF) + 1;

    logic [DW-1:0] div_q;
    logic [2:0]    bits_q;
    logic [7:0]    sh_q;
    logic          act_q;
    logic          sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bits_q <= '0;
            sh_q   <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
        end else if (load) begin
            sh_q   <= din;
            bits_q <= 3'd7;
            act_q  <= 1'b1;
            sclk_q <= 1'b0;
            div_q  <= '0;
        end else if (act_q) begin
            if (div_q == DW'(HALF - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bits_q == 3'd0) begin
                        act_q <= 1'b0;
                    end else begin
                        bits_q <= bits_q - 1'b1;
                        sh_q   <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign busy = act_q;
    assign sclk = sclk_q;
    assign sdo  = sh_q[7];
endmodule

// File: rtl/bitload_ctrl.sv
module bitload_ctrl #(
    parameter int ADDR_W      = 24,
    parameter int CNT_W       = 24,
    parameter int CHUNK       = 256,
    parameter int SCK_HALF    = 2,
    parameter int SETTLE_CYC  = 100000,
    parameter int HS_TIMEOUT  = 1000000,
    parameter int SELFCFG_CYC = 200000000,
    parameter int HAS_PROG    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    input  logic              rd_valid_i,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              prog_n_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic [2:0]        result_o
);
    import bitload_pkg::*;

    localparam int TMAX_A = (SETTLE_CYC > HS_TIMEOUT) ? SETTLE_CYC : HS_TIMEOUT;
    localparam int TMAX   = (TMAX_A > SELFCFG_CYC) ? TMAX_A : SELFCFG_CYC;
    localparam int TMR_W  = $clog2(TMAX + 1);
    localparam int CH_W   = $clog2(CHUNK + 1);

    bl_state_e         state_q, state_d;
    logic [CNT_W-1:0]  rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CH_W-1:0]   chunk_q;
    logic [1:0]        init_sync, done_sync;
    logic              init_s, done_s;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              tx_load, tx_busy;
    logic              prog_n_q, busy_q, rd_req_q;
    logic [2:0]        res_q;

    // pin synchronizers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_sync <= 2'b11;
            done_sync <= 2'b00;
        end else begin
            init_sync <= {init_sync[0], init_n_i};
            done_sync <= {done_sync[0], done_i};
        end
    end
    assign init_s = init_sync[1];
    assign done_s = done_sync[1];

    bitload_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
    );

    bitload_serial #(.HALF(SCK_HALF)) u_serial (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .din(rd_data_i),
        .busy(tx_busy), .sclk(sclk_o), .sdo(sdo_o)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tx_load  = 1'b0;
        unique case (state_q)
            S_IDLE: if (start_i) begin
                tmr_load = 1'b1;
                if (HAS_PROG != 0) begin
                    state_d = S_PROG_LOW;
                    tmr_val = TMR_W'(HS_TIMEOUT);
                end else begin
                    state_d = S_SELFCFG;
                    tmr_val = TMR_W'(SELFCFG_CYC);
                end
            end
            S_PROG_LOW: begin
                if (!init_s) begin
                    state_d  = S_PROG_REL;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HS_TIMEOUT);
                end else if (tmr_exp) begin
                    state_d = S_IDLE;
                end
            end
            S_PROG_REL: begin
                if (init_s)       state_d = S_CHUNK;
                else if (tmr_exp) state_d = S_IDLE;
            end
            S_CHUNK: begin
                if (rem_q == '0) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYC);
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_FETCH: if (rd_valid_i) begin
                state_d = S_SHIFT;
                tx_load = 1'b1;
            end
            S_SHIFT: if (!tx_busy) begin
                state_d = (chunk_q == CH_W'(1)) ? S_CHUNK : S_FETCH;
            end
            S_SETTLE:  if (tmr_exp) state_d = S_IDLE;
            S_SELFCFG: if (tmr_exp) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // address, remaining count and chunk counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            chunk_q <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                addr_q <= start_addr_i;
                rem_q  <= byte_count_i;
            end
            if (state_q == S_CHUNK && rem_q != '0) begin
                chunk_q <= (rem_q > CNT_W'(CHUNK)) ? CH_W'(CHUNK) : CH_W'(rem_q);
            end
            if (state_q == S_SHIFT && !tx_busy) begin
                addr_q  <= addr_q + 1'b1;
                rem_q   <= rem_q - 1'b1;
                chunk_q <= chunk_q - 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_n_q <= 1'b1;
            busy_q   <= 1'b0;
            rd_req_q <= 1'b0;
            res_q    <= RES_NONE;
        end else begin
            prog_n_q <= (state_d != S_PROG_LOW);
            busy_q   <= (state_d != S_IDLE);
            rd_req_q <= (state_d == S_FETCH);
            if (state_q == S_IDLE && state_d != S_IDLE)
                res_q <= RES_NONE;
            else if ((state_q == S_PROG_LOW || state_q == S_PROG_REL) && state_d == S_IDLE)
                res_q <= RES_TIMEOUT;
            else if (state_q == S_SETTLE && tmr_exp)
                res_q <= !init_s ? RES_CRC : (!done_s ? RES_NOTDONE : RES_OK);
            else if (state_q == S_SELFCFG && tmr_exp)
                res_q <= RES_OK;
        end
    end

    assign prog_n_o  = prog_n_q;
    assign busy_o    = busy_q;
    assign rd_req_o  = rd_req_q;
    assign rd_addr_o = addr_q;
    assign result_o  = res_q;
endmodule

// File: rtl/bitload_checks.sv
module bitload_checks #(
    parameter int ADDR_W = 24,
    parameter int CHUNK  = 256,
    parameter int CH_W   = $clog2(CHUNK + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_n,
    input logic              sclk,
    input logic              sdo,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic [2:0]        result,
    input logic [CH_W-1:0]   chunk_left
);
    a_r3_quiet_during_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (!rd_req && !sclk));

    a_r2_prog_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> busy);

    a_r5_sdo_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    a_r4_addr_held_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    a_r6_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_left <= CH_W'(CHUNK));

    a_r10_timeout_released: assert property (@(posedge clk) disable iff (!rst_n)
        (result == 3'd4) |-> prog_n);

    a_r12_result_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (result == 3'd0));
endmodule

bind bitload_ctrl bitload_checks #(.ADDR_W(ADDR_W), .CHUNK(CHUNK)) u_checks (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n_o), .sclk(sclk_o), .sdo(sdo_o),
    .rd_req(rd_req_o), .rd_addr(rd_addr_o), .busy(busy_o), .result(result_o),
    .chunk_left(chunk_q)
);

// File: tb/bitload_ctrl_bench.sv
module bitload_ctrl_bench;
    localparam int AW = 16, CW = 16, CHUNK = 16, HALF = 2;
    localparam int SETTLE = 40, HS = 100, SELF = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 0;
    logic [AW-1:0] saddr = '0;
    logic [CW-1:0] scount = '0;
    logic          rd_req, rd_valid = 0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          init_m = 1'b1, init_n, done_pin;
    logic          prog_n, sclk, sdo, busy;
    logic [2:0]    result;

    // self-configuring variant
    logic          s2_start = 0, s2_rdreq, s2_sclk, s2_sdo, s2_busy, s2_prog_n;
    logic [AW-1:0] s2_addr;
    logic [2:0]    s2_result;

    // FPGA model controls
    logic crc_mode = 0, done_mode = 1, stuck_high = 0, hold_low = 0;
    int   dly = 0;

    // bench bookkeeping
    int tests = 0, fails = 0, cyc = 0;
    int rx_bytes = 0, rx_bits = 0, rx_bad = 0, reads = 0, addr_err = 0, early = 0;
    int last_bit_cyc = 0, prog_low_seen = 0;
    logic [AW-1:0] exp_base = '0;
    logic [7:0] rx_sh = '0;
    bit finished = 0;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign init_n   = init_m & !(crc_mode && rx_bytes == int'(scount));
    assign done_pin = done_mode && (rx_bytes == int'(scount));

    bitload_ctrl #(.ADDR_W(AW), .CNT_W(CW), .CHUNK(CHUNK), .SCK_HALF(HALF),
                   .SETTLE_CYC(SETTLE), .HS_TIMEOUT(HS), .SELFCFG_CYC(SELF),
                   .HAS_PROG(1)) u_bitload_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(saddr),
        .byte_count_i(scount), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .rd_valid_i(rd_valid), .init_n_i(init_n),
        .done_i(done_pin), .prog_n_o(prog_n), .sclk_o(sclk), .sdo_o(sdo),
        .busy_o(busy), .result_o(result));

    bitload_ctrl #(.ADDR_W(AW), .CNT_W(CW), .CHUNK(CHUNK), .SCK_HALF(HALF),
                   .SETTLE_CYC(SETTLE), .HS_TIMEOUT(HS), .SELFCFG_CYC(SELF),
                   .HAS_PROG(0)) u_bitload_ctrl_selfcfg (
        .clk(clk), .rst_n(rst_n), .start_i(s2_start), .start_addr_i(16'h0100),
        .byte_count_i(16'd4), .rd_req_o(s2_rdreq), .rd_addr_o(s2_addr),
        .rd_data_i(8'h00), .rd_valid_i(1'b0), .init_n_i(1'b1),
        .done_i(1'b1), .prog_n_o(s2_prog_n), .sclk_o(s2_sclk), .sdo_o(s2_sdo),
        .busy_o(s2_busy), .result_o(s2_result));

    always @(posedge clk) cyc <= cyc + 1;

    // flash model with one-cycle latency, checks address order
    always @(posedge clk) begin
        rd_valid <= rd_req && !rd_valid;
        rd_data  <= pat(rd_addr);
        if (rd_req && !rd_valid) begin
            if (rd_addr != exp_base + AW'(reads)) addr_err <= addr_err + 1;
            reads <= reads + 1;
        end
    end

    // FPGA pin model
    always @(posedge clk) begin
        if (!rst_n) begin
            init_m <= 1'b1;
            dly    <= 0;
        end else if (stuck_high) begin
            init_m <= 1'b1;
        end else if (!prog_n) begin
            init_m <= 1'b0;
            dly    <= 20;
        end else if (dly != 0) begin
            dly <= dly - 1;
        end else begin
            init_m <= !hold_low;
        end
        if (rst_n && !init_m && (rd_req || sclk)) early <= early + 1;
        if (rst_n && !prog_n) prog_low_seen <= prog_low_seen + 1;
    end

    // serial receiver
    always @(posedge sclk) begin
        rx_sh   = {rx_sh[6:0], sdo};
        rx_bits = rx_bits + 1;
        last_bit_cyc = cyc;
        if (rx_bits % 8 == 0) begin
            if (rx_sh != pat(exp_base + AW'(rx_bytes))) rx_bad = rx_bad + 1;
            rx_bytes = rx_bytes + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic launch(input logic [AW-1:0] a, input int n);
        @(negedge clk);
        rx_bytes = 0; rx_bits = 0; rx_bad = 0;
        reads = 0; addr_err = 0; early = 0; prog_low_seen = 0;
        exp_base = a; saddr = a; scount = CW'(n);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check(prog_n === 1'b1, "R1 prog_n", int'(prog_n), 1);
        check(busy === 1'b0 && sclk === 1'b0 && rd_req === 1'b0, "R1 idle outputs",
              int'({busy, sclk, rd_req}), 0);
        check(result === 3'd0, "R1 result", int'(result), 0);
    endtask

    task automatic t_normal(input logic [AW-1:0] a, input int n, input string tag);
        int t_end;
        crc_mode = 0; done_mode = 1; stuck_high = 0; hold_low = 0;
        launch(a, n);
        wait_idle();
        t_end = cyc;
        check(prog_low_seen > 0 && prog_n, "R2 handshake pulse", prog_low_seen, 1);
        check(early == 0, "R3 nothing before init high", early, 0);
        check(reads == n && addr_err == 0, {tag, " R4 reads"}, reads, n);
        check(rx_bytes == n && rx_bad == 0 && rx_bits == 8 * n, {tag, " R5/R6 bytes"}, rx_bytes, n);
        if (n > 0) check(t_end - last_bit_cyc >= SETTLE, "R7 settle", t_end - last_bit_cyc, SETTLE);
        check(result == 3'd1, {tag, " R9 ok"}, int'(result), 1);
    endtask

    task automatic t_crc();
        crc_mode = 1; done_mode = 0;
        launch(16'h0200, 3);
        check(result == 3'd0, "R12 result cleared on start", int'(result), 0);
        wait_idle();
        check(result == 3'd2, "R8 crc", int'(result), 2);
        crc_mode = 0; done_mode = 1;
    endtask

    task automatic t_notdone();
        done_mode = 0;
        launch(16'h0300, 2);
        wait_idle();
        check(result == 3'd3, "R9 not done", int'(result), 3);
        done_mode = 1;
    endtask

    task automatic t_zero();
        launch(16'h0400, 0);
        wait_idle();
        check(reads == 0 && rx_bits == 0, "R13 no bytes", reads, 0);
        check(result == 3'd1, "R13 result", int'(result), 1);
    endtask

    task automatic t_restart_ignored();
        launch(16'h1000, 40);
        repeat (30) @(negedge clk);
        saddr = 16'h7777; scount = 16'd3; start = 1;
        @(negedge clk);
        start = 0; saddr = 16'h1000; scount = 16'd40;
        wait_idle();
        check(reads == 40 && addr_err == 0, "R12 restart ignored", reads, 40);
        check(rx_bytes == 40 && rx_bad == 0, "R6 chunked stream", rx_bytes, 40);
    endtask

    task automatic t_timeouts();
        stuck_high = 1;
        launch(16'h0500, 2);
        wait_idle();
        check(result == 3'd4 && prog_n, "R10 init never low", int'(result), 4);
        check(reads == 0, "R10 no reads", reads, 0);
        stuck_high = 0;
        repeat (5) @(negedge clk);
        hold_low = 1;
        launch(16'h0600, 2);
        wait_idle();
        check(result == 3'd4 && prog_n, "R10 init never high", int'(result), 4);
        hold_low = 0;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_selfcfg();
        int t0, dur;
        @(negedge clk);
        s2_start = 1; t0 = cyc;
        @(negedge clk);
        s2_start = 0;
        for (int i = 0; i < 1000 && (s2_busy || cyc - t0 < 3); i++) @(negedge clk);
        dur = cyc - t0;
        check(dur >= SELF && s2_result == 3'd1, "R11 self config", int'(s2_result), 1);
        check(s2_prog_n && !s2_rdreq && !s2_sclk, "R11 pins quiet",
              int'({s2_prog_n, s2_rdreq, s2_sclk}), 4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_normal(16'h0010, 5, "short");
        t_normal(16'h0FF8, 16, "exact chunk");
        t_normal(16'h2000, 37, "three chunks");
        t_crc();
        t_notdone();
        t_zero();
        t_restart_ignored();
        t_timeouts();
        t_selfcfg();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule